// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the 256-byte Type-0 configuration header of a single-function network controller. A bus-side agent, outside this block, turns configuration cycles into accesses on a simple internal port. That port carries a dword index, four byte enables and 32 bits of write data. Read data comes back one clock after the read strobe, together with a valid flag.

The header contains the following:
- fixed identity fields
- a command word and a status word whose error flags are cleared by writing ones
- I/O, memory and expansion-ROM base registers whose low bits are hardwired
- interrupt and latency fields
- one power-management capability

Hardware event inputs set the status flags and the PME status. The block drives the decode enables, the writable base bits, a gated system-error pulse, the power state and the PME request to the rest of the chip. The subsystem IDs and the card-information pointer come in on input ports.

Top module: `pci_cfg_space`

## Requirements
- R1: After the synchronous reset, dword 1 reads 0210_0007h: command 0007h, and status with bit 20 = 1 and bits 26:25 = 01. Every status error flag reads 0.
- R2: The following dwords are read-only:
  - dword 0 reads {device ID, vendor ID}.
  - dword 2 reads {class code, revision}.
  - dword 10 (28h) reads the `cis_ptr` input.
  - dword 11 (2Ch) reads {`sub_device_id`, `sub_vendor_id`}.
  
  Writes to any of these dwords change nothing.
- R3: The status flags are bits 31, 30, 29, 28 and 24. They are set by events:
  - `ev_addr_perr` or `ev_data_perr` sets bit 31.
  - a gated system error sets bit 30.
  - `ev_master_abort` sets bit 29.
  - `ev_target_abort` sets bit 28.
  - `ev_master_dperr` sets bit 24.
  
  Writing 1 to a flag clears it, and writing 0 leaves it unchanged. When an event and a clearing write fall in the same cycle, the event wins.
- R4: `serr_o` pulses high in the cycle after `ev_addr_perr` only when command bit 8 and command bit 6 are both 1. When it pulses, status bit 30 is set.
- R5: In the I/O base register (dword 4), bits 31:7 are writable, bits 6:1 read 0 and bit 0 reads 1. The memory base register (dword 5) behaves the same except that bit 0 reads 0.
- R6: In the ROM base register (dword 12, 30h), bits 31:18 and bit 0 are writable and bits 17:1 read 0. `rom_decode_en` is 1 only when ROM bit 0 and command bit 1 are both 1.
- R7: A write updates only the bytes whose enable is 1: `cfg_be[0]` selects bits 7:0 and `cfg_be[3]` selects bits 31:24.
- R8: Dword 13 (34h) reads 0000_0050h. Dword 20 (50h) reads C002_0001h: capability ID 01h, next pointer 00h, version 2, and PME support 11000b in bits 31:27.
- R9: The power-management control/status word is dword 21 (54h):
  - Bits 1:0 hold the power state. A write of 00 or 11 is accepted, and a write of 01 or 10 is ignored.
  - Bit 8 is PME enable and resets to 1.
  - Bit 15 is PME status. `pme_event` sets it and writing 1 clears it.
  - `pme_o` equals PME status AND PME enable.
- R10: Dword 15 (3Ch) resets to 2814_0100h: maximum latency 28h, minimum grant 14h and interrupt pin 01h are fixed, and the interrupt line in bits 7:0 is writable. In dword 3, the cache-line size (bits 7:0) and the latency timer (bits 15:8) are writable, and bits 31:16 read 0.
- R11: Dwords that are not implemented read 0.
- R12: `cfg_rvalid` is high in the cycle after `cfg_rd`, and `cfg_rdata` holds the addressed dword in that cycle.
- R13: `io_space_en`, `mem_space_en` and `bus_master_en` follow command bits 0, 1 and 2. `io_base`, `mem_base` and `rom_base` carry the writable upper bits of their base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 6 | Dword index |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the strobe |
| cfg_rvalid | output | 1 | Read data valid |
| sub_vendor_id | input | 16 | Subsystem vendor ID |
| sub_device_id | input | 16 | Subsystem device ID |
| cis_ptr | input | 32 | Card information structure pointer |
| ev_addr_perr | input | 1 | Address parity error detected |
| ev_data_perr | input | 1 | Data parity error detected |
| ev_master_dperr | input | 1 | Parity error reported while master |
| ev_master_abort | input | 1 | Master abort received |
| ev_target_abort | input | 1 | Target abort received |
| pme_event | input | 1 | Wake event that sets PME status |
| io_space_en | output | 1 | I/O decode enable |
| mem_space_en | output | 1 | Memory decode enable |
| bus_master_en | output | 1 | Bus mastering enable |
| io_base | output | 25 | I/O base bits 31:7 |
| mem_base | output | 25 | Memory base bits 31:7 |
| rom_base | output | 14 | ROM base bits 31:18 |
| rom_decode_en | output | 1 | ROM window decode enable |
| serr_o | output | 1 | System error pulse |
| pm_state | output | 2 | Current power state |
| pme_o | output | 1 | PME request |

## Verification
An event input can set a status flag in the same cycle that software writes a one to clear that flag. The bench raises `ev_master_abort` in the very cycle that a clearing write to bit 29 is presented. It then reads the status word, and the flag must still be set. A second write with no event must then clear it, which shows that the earlier result came from the collision and not from a clear that failed.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam int A_ID     = 0;
  localparam int A_CMDSTS = 1;
  localparam int A_CLASS  = 2;
  localparam int A_MISC   = 3;
  localparam int A_IOBAR  = 4;
  localparam int A_MEMBAR = 5;
  localparam int A_CIS    = 10;
  localparam int A_SUBID  = 11;
  localparam int A_ROMBAR = 12;
  localparam int A_CAPPTR = 13;
  localparam int A_INTR   = 15;

  // status upper half: flags in bits 15,14,13,12,8 (dword bits 31,30,29,28,24)
  localparam logic [15:0] STS_FLAG_MASK = 16'hF100;
  localparam logic [15:0] STS_CONST     = 16'h0210;
  localparam logic [15:0] CMD_WMASK     = 16'h0147;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] CMD_RESET = 16'h0007
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        ev_addr_perr,
  input  logic        ev_data_perr,
  input  logic        ev_master_dperr,
  input  logic        ev_master_abort,
  input  logic        ev_target_abort,
  output logic [15:0] cmd_q,
  output logic [15:0] sts_word,
  output logic        serr_o
);

  logic [15:0] flags_q;
  logic [15:0] set_v;
  logic [15:0] clr_v;
  logic        serr_fire;
  logic [31:0] merged;

  assign serr_fire = ev_addr_perr & cmd_q[8] & cmd_q[6];
  assign merged    = be_merge({16'h0, cmd_q}, wdata, be);

  always_comb begin
    set_v     = '0;
    set_v[15] = ev_addr_perr | ev_data_perr;
    set_v[14] = serr_fire;
    set_v[13] = ev_master_abort;
    set_v[12] = ev_target_abort;
    set_v[8]  = ev_master_dperr;
    clr_v     = wr_en ? (wdata[31:16] & be_mask(be)[31:16]) : 16'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_RESET;
      flags_q <= '0;
      serr_o  <= 1'b0;
    end else begin
      if (wr_en) cmd_q <= merged[15:0] & CMD_WMASK;
      flags_q <= ((flags_q & ~clr_v) | set_v) & STS_FLAG_MASK;
      serr_o  <= serr_fire;
    end
  end

  assign sts_word = flags_q | STS_CONST;

endmodule

// File: rtl/cfg_bar.sv
module cfg_bar
  import pcicfg_pkg::*;
#(
  parameter logic [31:0] WMASK   = 32'hFFFF_FF80,
  parameter logic [31:0] RO_BITS = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] value
);

  logic [31:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= be_merge(q, wdata, be) & WMASK;
  end

  assign value = q | RO_BITS;

endmodule

// File: rtl/cfg_pm.sv
module cfg_pm (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        pme_event,
  output logic [31:0] pmcsr,
  output logic [1:0]  pm_state,
  output logic        pme_o
);

  logic pme_en_q;
  logic pme_sts_q;
  logic state_ok;

  assign state_ok = (wdata[1:0] == 2'b00) || (wdata[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_state  <= 2'b00;
      pme_en_q  <= 1'b1;
      pme_sts_q <= 1'b0;
    end else begin
      if (wr_en && be[0] && state_ok) pm_state <= wdata[1:0];
      if (wr_en && be[1])             pme_en_q <= wdata[8];
      pme_sts_q <= pme_event | (pme_sts_q & ~(wr_en & be[1] & wdata[15]));
    end
  end

  assign pmcsr = {16'h0, pme_sts_q, 6'h0, pme_en_q, 6'h0, pm_state};
  assign pme_o = pme_sts_q & pme_en_q;

endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pcicfg_pkg::*;
#(
  parameter int          CFG_BYTES     = 256,
  parameter int          IO_WIN_BYTES  = 128,
  parameter int          ROM_WIN_BYTES = 262144,
  parameter logic [15:0] VENDOR_ID     = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID     = 16'h0C21,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [7:0]  REVISION      = 8'h12,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h14,
  parameter logic [7:0]  MAX_LAT       = 8'h28,
  parameter logic [7:0]  CAP_OFFSET    = 8'h50,
  parameter logic [4:0]  PME_SUPPORT   = 5'b11000,
  localparam int ADDR_W  = $clog2(CFG_BYTES / 4),
  localparam int IO_LSB  = $clog2(IO_WIN_BYTES),
  localparam int ROM_LSB = $clog2(ROM_WIN_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_rd,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                cfg_rvalid,
  input  logic [15:0]         sub_vendor_id,
  input  logic [15:0]         sub_device_id,
  input  logic [31:0]         cis_ptr,
  input  logic                ev_addr_perr,
  input  logic                ev_data_perr,
  input  logic                ev_master_dperr,
  input  logic                ev_master_abort,
  input  logic                ev_target_abort,
  input  logic                pme_event,
  output logic                io_space_en,
  output logic                mem_space_en,
  output logic                bus_master_en,
  output logic [31:IO_LSB]    io_base,
  output logic [31:IO_LSB]    mem_base,
  output logic [31:ROM_LSB]   rom_base,
  output logic                rom_decode_en,
  output logic                serr_o,
  output logic [1:0]          pm_state,
  output logic                pme_o
);

  localparam logic [31:0] IO_WMASK  = ~((32'd1 << IO_LSB) - 32'd1);
  localparam logic [31:0] ROM_WMASK = ~((32'd1 << ROM_LSB) - 32'd1) | 32'd1;
  localparam int          CAP_DW    = int'(CAP_OFFSET) / 4;
  localparam int          PMCSR_DW  = CAP_DW + 1;
  localparam logic [15:0] PMC_WORD  = {PME_SUPPORT, 8'h00, 3'b010};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  logic [15:0] cmd_q;
  logic [15:0] sts_word;
  logic [31:0] iobar_v, membar_v, rombar_v, pmcsr_v;
  logic [7:0]  cls_q, lat_q, intline_q;
  logic [31:0] rd_mux;

  cfg_cmd_status #(.CMD_RESET(16'h0007)) u_cmdsts (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit(cfg_addr, A_CMDSTS)),
    .be(cfg_be), .wdata(cfg_wdata),
    .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr),
    .ev_master_dperr(ev_master_dperr), .ev_master_abort(ev_master_abort),
    .ev_target_abort(ev_target_abort),
    .cmd_q(cmd_q), .sts_word(sts_word), .serr_o(serr_o)
  );

  cfg_bar #(.WMASK(IO_WMASK), .RO_BITS(32'h1)) u_iobar (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit(cfg_addr, A_IOBAR)),
    .be(cfg_be), .wdata(cfg_wdata), .value(iobar_v)
  );

  cfg_bar #(.WMASK(IO_WMASK), .RO_BITS(32'h0)) u_membar (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit(cfg_addr, A_MEMBAR)),
    .be(cfg_be), .wdata(cfg_wdata), .value(membar_v)
  );

  cfg_bar #(.WMASK(ROM_WMASK), .RO_BITS(32'h0)) u_rombar (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit(cfg_addr, A_ROMBAR)),
    .be(cfg_be), .wdata(cfg_wdata), .value(rombar_v)
  );

  cfg_pm u_pm (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit(cfg_addr, PMCSR_DW)),
    .be(cfg_be), .wdata(cfg_wdata), .pme_event(pme_event),
    .pmcsr(pmcsr_v), .pm_state(pm_state), .pme_o(pme_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q     <= '0;
      lat_q     <= '0;
      intline_q <= '0;
    end else if (cfg_wr) begin
      if (hit(cfg_addr, A_MISC) && cfg_be[0]) cls_q     <= cfg_wdata[7:0];
      if (hit(cfg_addr, A_MISC) && cfg_be[1]) lat_q     <= cfg_wdata[15:8];
      if (hit(cfg_addr, A_INTR) && cfg_be[0]) intline_q <= cfg_wdata[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(cfg_addr, A_ID))     rd_mux = {DEVICE_ID, VENDOR_ID};
    else if (hit(cfg_addr, A_CMDSTS)) rd_mux = {sts_word, cmd_q};
    else if (hit(cfg_addr, A_CLASS))  rd_mux = {CLASS_CODE, REVISION};
    else if (hit(cfg_addr, A_MISC))   rd_mux = {16'h0, lat_q, cls_q};
    else if (hit(cfg_addr, A_IOBAR))  rd_mux = iobar_v;
    else if (hit(cfg_addr, A_MEMBAR)) rd_mux = membar_v;
    else if (hit(cfg_addr, A_CIS))    rd_mux = cis_ptr;
    else if (hit(cfg_addr, A_SUBID))  rd_mux = {sub_device_id, sub_vendor_id};
    else if (hit(cfg_addr, A_ROMBAR)) rd_mux = rombar_v;
    else if (hit(cfg_addr, A_CAPPTR)) rd_mux = {24'h0, CAP_OFFSET};
    else if (hit(cfg_addr, A_INTR))   rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, intline_q};
    else if (hit(cfg_addr, CAP_DW))   rd_mux = {PMC_WORD, 8'h00, 8'h01};
    else if (hit(cfg_addr, PMCSR_DW)) rd_mux = pmcsr_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rdata  <= cfg_rd ? rd_mux : 32'h0;
      cfg_rvalid <= cfg_rd;
    end
  end

  assign io_space_en   = cmd_q[0];
  assign mem_space_en  = cmd_q[1];
  assign bus_master_en = cmd_q[2];
  assign io_base       = iobar_v[31:IO_LSB];
  assign mem_base      = membar_v[31:IO_LSB];
  assign rom_base      = rombar_v[31:ROM_LSB];
  assign rom_decode_en = rombar_v[0] & cmd_q[1];

endmodule

// File: rtl/pcicfg_chk.sv
module pcicfg_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_rd,
  input logic        cfg_rvalid,
  input logic [15:0] cmd,
  input logic [15:0] sts,
  input logic        ev_addr_perr,
  input logic        ev_master_abort,
  input logic        serr_o,
  input logic        rom_decode_en,
  input logic        mem_space_en,
  input logic [1:0]  pm_state
);

  p_rvalid_follows_rd_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid);

  p_serr_gated_r4: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> $past(ev_addr_perr && cmd[8] && cmd[6]));

  p_serr_flags_status_r4: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> sts[14]);

  p_event_beats_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ev_master_abort |=> sts[13]);

  p_rom_needs_mem_r6: assert property (@(posedge clk) disable iff (rst)
    rom_decode_en |-> mem_space_en);

  p_pm_state_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'b00) || (pm_state == 2'b11));

endmodule

bind pci_cfg_space pcicfg_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_rvalid(cfg_rvalid),
  .cmd(cmd_q), .sts(sts_word), .ev_addr_perr(ev_addr_perr),
  .ev_master_abort(ev_master_abort), .serr_o(serr_o),
  .rom_decode_en(rom_decode_en), .mem_space_en(mem_space_en),
  .pm_state(pm_state)
);

// File: tb/pci_cfg_space_tb.sv
`timescale 1ns/1ps
module pci_cfg_space_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [15:0] sub_vendor_id = 16'hBEEF;
  logic [15:0] sub_device_id = 16'h4321;
  logic [31:0] cis_ptr = 32'h0000_0801;
  logic        ev_addr_perr = 0, ev_data_perr = 0, ev_master_dperr = 0;
  logic        ev_master_abort = 0, ev_target_abort = 0, pme_event = 0;
  logic        io_space_en, mem_space_en, bus_master_en;
  logic [31:7] io_base, mem_base;
  logic [31:18] rom_base;
  logic        rom_decode_en, serr_o, pme_o;
  logic [1:0]  pm_state;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pci_cfg_space dut_i (
    .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .sub_vendor_id(sub_vendor_id),
    .sub_device_id(sub_device_id), .cis_ptr(cis_ptr),
    .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr),
    .ev_master_dperr(ev_master_dperr), .ev_master_abort(ev_master_abort),
    .ev_target_abort(ev_target_abort), .pme_event(pme_event),
    .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .bus_master_en(bus_master_en), .io_base(io_base), .mem_base(mem_base),
    .rom_base(rom_base), .rom_decode_en(rom_decode_en), .serr_o(serr_o),
    .pm_state(pm_state), .pme_o(pme_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a[5:0];
    cfg_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_addr = a[5:0];
    cfg_wdata = d;
    cfg_be = be;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 io_en reset", {31'h0, io_space_en}, 32'h1);
    check("R13 mem_en reset", {31'h0, mem_space_en}, 32'h1);
    check("R13 master_en reset", {31'h0, bus_master_en}, 32'h1);
    check("R12 rvalid idle", {31'h0, cfg_rvalid}, 32'h0);

    rd(0, 32'h0C21_1AB5, "R2 id");
    rd(1, 32'h0210_0007, "R1 cmd/status reset");
    rd(2, 32'h0200_0012, "R2 class/rev");
    rd(3, 32'h0, "R10 misc reset");
    rd(10, 32'h0000_0801, "R2 cis");
    rd(11, 32'h4321_BEEF, "R2 subsystem");
    rd(13, 32'h0000_0050, "R8 cap ptr");
    rd(15, 32'h2814_0100, "R10 intr reset");
    rd(20, 32'hC002_0001, "R8 pm cap");
    rd(21, 32'h0000_0100, "R9 pmcsr reset");
    rd(7, 32'h0, "R11 hole 1Ch");
    rd(30, 32'h0, "R11 hole 78h");
    rd(63, 32'h0, "R11 hole FCh");

    wr(0, 32'hFFFF_FFFF, 4'hF);
    wr(11, 32'h0, 4'hF);
    rd(0, 32'h0C21_1AB5, "R2 id after write");
    rd(11, 32'h4321_BEEF, "R2 subsystem after write");

    wr(4, 32'hFFFF_FFFF, 4'hF);
    wr(5, 32'hFFFF_FFFF, 4'hF);
    rd(4, 32'hFFFF_FF81, "R5 io bar mask");
    rd(5, 32'hFFFF_FF80, "R5 mem bar mask");
    check("R13 io_base", {7'h0, io_base}, 32'h01FF_FFFF);
    wr(4, 32'h1234_5678, 4'b0001);
    rd(4, 32'hFFFF_FF01, "R7 byte0 write");
    wr(4, 32'h00AB_0000, 4'b0100);
    rd(4, 32'hFFAB_FF01, "R7 byte2 write");
    check("R13 io_base after byte write", {7'h0, io_base}, 32'hFFAB_FF00 >> 7);

    wr(15, 32'h0000_005A, 4'b0001);
    wr(15, 32'hFFFF_FFFF, 4'b1110);
    rd(15, 32'h2814_015A, "R10 int line");
    wr(3, 32'hFFFF_FFFF, 4'hF);
    rd(3, 32'h0000_FFFF, "R10 cache/latency");

    wr(12, 32'hFFFF_FFFF, 4'hF);
    rd(12, 32'hFFFC_0001, "R6 rom bar mask");
    check("R6 rom decode on", {31'h0, rom_decode_en}, 32'h1);
    check("R6 rom_base", {18'h0, rom_base}, 32'h0000_3FFF);
    wr(1, 32'h0000_0005, 4'b0011);
    check("R6 rom decode needs mem", {31'h0, rom_decode_en}, 32'h0);
    check("R13 mem_en off", {31'h0, mem_space_en}, 32'h0);
    rd(1, 32'h0210_0005, "R1 cmd write");
    wr(1, 32'h0000_0007, 4'b0011);
    wr(12, 32'hFFFC_0000, 4'hF);
    check("R6 rom decode needs enable", {31'h0, rom_decode_en}, 32'h0);

    // address parity error, gating off
    @(negedge clk); ev_addr_perr = 1;
    @(negedge clk); ev_addr_perr = 0;
    check("R4 serr gated off", {31'h0, serr_o}, 32'h0);
    rd(1, 32'h8210_0007, "R3 bit31 set");
    wr(1, 32'h8000_0000, 4'b1100);
    rd(1, 32'h0210_0007, "R3 bit31 cleared");
    wr(1, 32'h0000_0047, 4'b0011);
    @(negedge clk); ev_addr_perr = 1;
    @(negedge clk); ev_addr_perr = 0;
    check("R4 serr needs bit8", {31'h0, serr_o}, 32'h0);
    wr(1, 32'h0000_0147, 4'b0011);
    @(negedge clk); ev_addr_perr = 1;
    @(negedge clk); ev_addr_perr = 0;
    check("R4 serr asserted", {31'h0, serr_o}, 32'h1);
    @(negedge clk);
    check("R4 serr one pulse", {31'h0, serr_o}, 32'h0);
    rd(1, 32'hC210_0147, "R4 bit30 set");
    wr(1, 32'hC000_0000, 4'b1100);
    rd(1, 32'h0210_0147, "R3 clear 31/30");

    @(negedge clk); ev_master_abort = 1;
    @(negedge clk); ev_master_abort = 0;
    wr(1, 32'h0000_0000, 4'b1100);
    rd(1, 32'h2210_0147, "R3 zero write keeps flag");
    // collision: event and clearing write in the same cycle
    @(negedge clk);
    ev_master_abort = 1;
    cfg_addr = 6'd1; cfg_wdata = 32'h2000_0000; cfg_be = 4'b1100; cfg_wr = 1;
    @(negedge clk);
    ev_master_abort = 0; cfg_wr = 0;
    rd(1, 32'h2210_0147, "R3 set wins over clear");
    wr(1, 32'h2000_0000, 4'b1100);
    rd(1, 32'h0210_0147, "R3 clear after collision");
    @(negedge clk); ev_target_abort = 1; ev_master_dperr = 1;
    @(negedge clk); ev_target_abort = 0; ev_master_dperr = 0;
    rd(1, 32'h1310_0147, "R3 bits 28/24 set");
    wr(1, 32'hFFFF_0000, 4'b1100);
    rd(1, 32'h0210_0147, "R3 clear all, ro bits kept");

    wr(21, 32'h0000_0001, 4'b0001);
    rd(21, 32'h0000_0100, "R9 state 01 ignored");
    wr(21, 32'h0000_0003, 4'b0001);
    rd(21, 32'h0000_0103, "R9 state 11 taken");
    check("R9 pm_state port", {30'h0, pm_state}, 32'h3);
    wr(21, 32'h0000_0002, 4'b0001);
    rd(21, 32'h0000_0103, "R9 state 10 ignored");
    wr(21, 32'h0000_0000, 4'b0001);
    @(negedge clk); pme_event = 1;
    @(negedge clk); pme_event = 0;
    check("R9 pme_o asserted", {31'h0, pme_o}, 32'h1);
    rd(21, 32'h0000_8100, "R9 pme status set");
    wr(21, 32'h0000_0000, 4'b0010);
    check("R9 pme_o masked", {31'h0, pme_o}, 32'h0);
    rd(21, 32'h0000_8000, "R9 pme enable cleared");
    wr(21, 32'h0000_8000, 4'b0010);
    rd(21, 32'h0000_0000, "R9 pme status cleared");

    repeat (3) @(negedge clk);
    check("R12 all reads returned", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule